// File: doc/BRIEF.md
# Channel Note-Duration Counter

This block times how long one square-wave sound channel keeps sounding. Software writes two byte registers: a control byte that carries a hold flag, and a length byte whose upper five bits select a note duration from a fixed 32-entry table. The lower three bits of the length byte are kept as the upper part of the channel's 11-bit timer period. A separate channel-enable bit gates loading, and clearing that bit silences the channel at once.

A frame sequencer outside the block supplies a half-frame strobe. On each strobe the 8-bit duration count steps down toward zero unless it is held or already at zero. The block drives the count, a silence flag for the mixer, and a one-cycle start pulse for the envelope generator.

Top module: `chan_len_counter`

## Requirements
- R1: After a synchronous active-low reset the count is 0, the silence flag is 1, the start pulse is 0, the period-high output is 0, the hold flag is clear and the channel is disabled.
- R2: A half-frame strobe decrements a nonzero count by one, with the result visible one cycle after the strobe, when the hold flag is clear.
- R3: The hold flag is bit 5 of the control byte. While it is set, a half-frame strobe leaves the count unchanged.
- R4: A count of zero stays zero on a half-frame strobe. It does not wrap.
- R5: With the channel enabled, a length-byte write loads the count on the next cycle with entry len[7:3] of the table 10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14,12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30 (index 0 first).
- R6: With the channel disabled, a length-byte write leaves the count unchanged and raises no start pulse.
- R7: Writing the enable bit as 0 forces the count to 0 on the next cycle. Writing it as 1 leaves the count unchanged. A length write in the same cycle as enabling still sees the channel as disabled.
- R8: The start pulse is high for exactly the one cycle in which a loaded table value first appears on the count output, and at no other time.
- R9: The silence flag equals 1 exactly when the count is 0.
- R10: Every length-byte write, enabled or not, sets the 3-bit period-high output to len[2:0] on the next cycle.
- R11: Priority within one cycle: disabling the channel first, then a length load, then a half-frame decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_we | input | 1 | Control-byte write strobe |
| ctrl_data | input | 8 | Control byte; bit 5 is the hold flag |
| len_we | input | 1 | Length-byte write strobe |
| len_data | input | 8 | Length byte; [7:3] table index, [2:0] period high |
| en_we | input | 1 | Enable-bit write strobe |
| en_bit | input | 1 | Channel enable value |
| half_tick | input | 1 | Half-frame strobe |
| count | output | 8 | Remaining duration |
| silent | output | 1 | Count is zero |
| env_start | output | 1 | One-cycle envelope start pulse |
| period_hi | output | 3 | Upper timer-period bits |

## Verification
A length-byte load and a half-frame decrement can land on the same clock edge. The bench provokes this by asserting len_we and half_tick together on a running count and expects the fresh table value with no decrement applied. Disabling the channel can also coincide with a length load. The bench drives both strobes in the same cycle and expects a zero count and no start pulse.

// File: rtl/chan_len_pkg.sv
// Package: shared widths and the note-duration lookup.
// Assumes the table values fit in an 8-bit count.
package chan_len_pkg;
    localparam int CNT_W   = 8;
    localparam int IDX_W   = 5;
    localparam int PHI_W   = 3;
    localparam int HOLD_BIT = 5;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [IDX_W-1:0] idx_t;

    // Map a 5-bit duration index to its count value.
    function automatic cnt_t dur_lookup(input idx_t i);
        cnt_t v;
        case (i)
            5'd0:  v = 8'd10;   5'd1:  v = 8'd254;
            5'd2:  v = 8'd20;   5'd3:  v = 8'd2;
            5'd4:  v = 8'd40;   5'd5:  v = 8'd4;
            5'd6:  v = 8'd80;   5'd7:  v = 8'd6;
            5'd8:  v = 8'd160;  5'd9:  v = 8'd8;
            5'd10: v = 8'd60;   5'd11: v = 8'd10;
            5'd12: v = 8'd14;   5'd13: v = 8'd12;
            5'd14: v = 8'd26;   5'd15: v = 8'd14;
            5'd16: v = 8'd12;   5'd17: v = 8'd16;
            5'd18: v = 8'd24;   5'd19: v = 8'd18;
            5'd20: v = 8'd48;   5'd21: v = 8'd20;
            5'd22: v = 8'd96;   5'd23: v = 8'd22;
            5'd24: v = 8'd192;  5'd25: v = 8'd24;
            5'd26: v = 8'd72;   5'd27: v = 8'd26;
            5'd28: v = 8'd16;   5'd29: v = 8'd28;
            5'd30: v = 8'd32;   default: v = 8'd30;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/chan_len_decode.sv
// Module: chan_len_decode
// Splits a length byte into its duration load value and period-high field.
// Purely combinational. Assumes the byte layout [7:3] index, [2:0] period high.
module chan_len_decode
    import chan_len_pkg::*;
(
    input  logic [7:0]       len_data,
    output cnt_t             load_val,
    output logic [PHI_W-1:0] per_hi
);
    idx_t idx;

    // Field split and table lookup.
    always_comb begin
        idx      = len_data[7:PHI_W];
        load_val = dur_lookup(idx);
        per_hi   = len_data[PHI_W-1:0];
    end
endmodule

// File: rtl/chan_len_regs.sv
// Module: chan_len_regs
// Holds the hold flag, the channel enable and the period-high field.
// Assumes one-cycle write strobes; synchronous active-low reset.
module chan_len_regs
    import chan_len_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_data,
    input  logic             len_we,
    input  logic [PHI_W-1:0] per_hi_in,
    input  logic             en_we,
    input  logic             en_bit,
    output logic             hold_q,
    output logic             enable_q,
    output logic [PHI_W-1:0] per_hi_q
);
    // Capture the hold flag from control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= 1'b0;
        else if (ctrl_we) hold_q <= ctrl_data[HOLD_BIT];
    end

    // Capture the channel enable.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable_q <= 1'b0;
        else if (en_we) enable_q <= en_bit;
    end

    // Capture the period-high field on every length write.
    always_ff @(posedge clk) begin
        if (!rst_n)      per_hi_q <= '0;
        else if (len_we) per_hi_q <= per_hi_in;
    end
endmodule

// File: rtl/chan_len_count.sv
// Module: chan_len_count
// The duration down-counter with its priority order: clear, then load, then decrement.
// Assumes the load value is never zero, so a load always produces a start pulse.
module chan_len_count
    import chan_len_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  cnt_t load_val,
    input  logic half_tick,
    input  logic hold,
    output cnt_t cnt_q,
    output logic start_q
);
    logic dec_ok;

    // Decide whether a half-frame strobe may step the count.
    always_comb dec_ok = half_tick && !hold && (cnt_q != '0);

    // Update the count.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (load)   cnt_q <= load_val;
        else if (dec_ok) cnt_q <= cnt_q - cnt_t'(1);
    end

    // Raise the start pulse alongside a load.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= load && !clr;
    end
endmodule

// File: rtl/chan_len_counter.sv
// Module: chan_len_counter (top)
// Per-channel note-duration counter. It loads from the duration table on an enabled
// length write, steps down on half-frame strobes unless held, and is forced to zero
// when the channel is disabled. Assumes single-cycle strobes from the register bus.
module chan_len_counter
    import chan_len_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_data,
    input  logic             len_we,
    input  logic [7:0]       len_data,
    input  logic             en_we,
    input  logic             en_bit,
    input  logic             half_tick,
    output logic [CNT_W-1:0] count,
    output logic             silent,
    output logic             env_start,
    output logic [PHI_W-1:0] period_hi
);
    cnt_t             load_val;
    logic [PHI_W-1:0] per_hi_dec;
    logic             hold_q;
    logic             enable_q;
    logic             clr;
    logic             load;
    cnt_t             cnt_q;

    chan_len_decode dec_i (
        .len_data (len_data),
        .load_val (load_val),
        .per_hi   (per_hi_dec)
    );

    chan_len_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .ctrl_data (ctrl_data),
        .len_we    (len_we),
        .per_hi_in (per_hi_dec),
        .en_we     (en_we),
        .en_bit    (en_bit),
        .hold_q    (hold_q),
        .enable_q  (enable_q),
        .per_hi_q  (period_hi)
    );

    // Form the clear and load requests from the strobes and the stored enable.
    always_comb begin
        clr  = en_we && !en_bit;
        load = len_we && enable_q;
    end

    chan_len_count cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .load      (load),
        .load_val  (load_val),
        .half_tick (half_tick),
        .hold      (hold_q),
        .cnt_q     (cnt_q),
        .start_q   (env_start)
    );

    // Drive the count and the silence flag.
    always_comb begin
        count  = cnt_q;
        silent = (cnt_q == '0);
    end
endmodule

// File: rtl/chan_len_counter_chk.sv
// Module: chan_len_counter_chk
// Property checker bound to chan_len_counter. It watches the ports and the stored hold and enable state.
module chan_len_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       len_we,
    input logic       en_we,
    input logic       en_bit,
    input logic       half_tick,
    input logic [7:0] count,
    input logic       silent,
    input logic       env_start,
    input logic       hold_q,
    input logic       enable_q
);
    // R2: an unheld strobe on a nonzero count with no other request steps down by one.
    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (half_tick && !hold_q && count != 8'd0 && !len_we && !en_we)
        |=> count == $past(count) - 8'd1);

    // R3: a held count does not move.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (half_tick && hold_q && !len_we && !en_we) |=> $stable(count));

    // R4: zero does not wrap.
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count == 8'd0 && !len_we) |=> count == 8'd0);

    // R6: a write while disabled has no effect on the count.
    a_r6_disabled_write: assert property (@(posedge clk) disable iff (!rst_n)
        (len_we && !enable_q && !half_tick && !en_we) |=> $stable(count));

    // R7: disabling clears the count.
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && !en_bit) |=> count == 8'd0);

    // R8: a start pulse always comes with a nonzero loaded count.
    a_r8_start_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        env_start |-> count != 8'd0);

    // R8: the start pulse lasts one cycle when no second load follows.
    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        (env_start && !len_we) |=> !env_start);

    // R9: the silence flag tracks a zero count.
    a_r9_silent: assert property (@(posedge clk) disable iff (!rst_n)
        silent == (count == 8'd0));
endmodule

bind chan_len_counter chan_len_counter_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_we    (len_we),
    .en_we     (en_we),
    .en_bit    (en_bit),
    .half_tick (half_tick),
    .count     (count),
    .silent    (silent),
    .env_start (env_start),
    .hold_q    (hold_q),
    .enable_q  (enable_q)
);

// File: tb/chan_len_counter_tb_top.sv
// Directed bench for chan_len_counter. Each task drives one scenario and checks its own results.
module chan_len_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctrl_we, len_we, en_we, en_bit, half_tick;
    logic [7:0] ctrl_data, len_data;
    logic [7:0] count;
    logic       silent, env_start;
    logic [2:0] period_hi;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int exp_tab [32] = '{10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14,
                         12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30};

    always #2.5 clk = ~clk;

    chan_len_counter dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_data(ctrl_data),
        .len_we(len_we), .len_data(len_data), .en_we(en_we), .en_bit(en_bit),
        .half_tick(half_tick), .count(count), .silent(silent),
        .env_start(env_start), .period_hi(period_hi)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes at the falling edge, then release them just after the rising edge.
    task automatic cycle(input bit cw, input logic [7:0] cd, input bit lw, input logic [7:0] ld,
                         input bit ew, input bit eb, input bit ht);
        @(negedge clk);
        ctrl_we = cw; ctrl_data = cd; len_we = lw; len_data = ld;
        en_we = ew; en_bit = eb; half_tick = ht;
        @(posedge clk); #1;
        ctrl_we = 0; len_we = 0; en_we = 0; half_tick = 0;
    endtask

    task automatic idle();
        cycle(0, 8'h00, 0, 8'h00, 0, 0, 0);
    endtask

    task automatic t_reset();
        chk("R1 count", count, 0);
        chk("R1 silent", silent, 1);
        chk("R1 env_start", env_start, 0);
        chk("R1 period_hi", period_hi, 0);
        cycle(0, 8'h00, 1, 8'h08, 0, 0, 0);      // disabled after reset: no load
        chk("R1 disabled after reset", count, 0);
    endtask

    task automatic t_load_all();
        cycle(0, 8'h00, 0, 8'h00, 1, 1, 0);      // enable
        chk("R7 enable no effect", count, 0);
        for (int i = 0; i < 32; i++) begin
            cycle(0, 8'h00, 1, 8'((i << 3) | (i & 7)), 0, 0, 0);
            chk("R5 table load", count, exp_tab[i]);
            chk("R8 start pulse", env_start, 1);
            chk("R10 period_hi", period_hi, i & 7);
            chk("R9 silent low", silent, 0);
            idle();
            chk("R8 start ends", env_start, 0);
        end
    endtask

    task automatic t_decrement();
        cycle(0, 8'h00, 1, 8'd3 << 3, 0, 0, 0);  // loads 2
        chk("R5 load 2", count, 2);
        cycle(0, 8'h00, 0, 8'h00, 0, 0, 1);
        chk("R2 step to 1", count, 1);
        idle();
        chk("R2 no strobe no step", count, 1);
        cycle(0, 8'h00, 0, 8'h00, 0, 0, 1);
        chk("R2 step to 0", count, 0);
        chk("R9 silent at 0", silent, 1);
        cycle(0, 8'h00, 0, 8'h00, 0, 0, 1);
        chk("R4 stays 0", count, 0);
    endtask

    task automatic t_hold();
        cycle(1, 8'h20, 0, 8'h00, 0, 0, 0);      // hold via bit 5
        cycle(0, 8'h00, 1, 8'h00, 0, 0, 0);      // load 10
        cycle(0, 8'h00, 0, 8'h00, 0, 0, 1);
        chk("R3 held", count, 10);
        cycle(1, 8'hDF, 0, 8'h00, 0, 0, 0);      // bit 5 clear, other bits set
        cycle(0, 8'h00, 0, 8'h00, 0, 0, 1);
        chk("R3 released", count, 9);
    endtask

    task automatic t_disabled();
        cycle(0, 8'h00, 0, 8'h00, 1, 0, 0);
        chk("R7 disable clears", count, 0);
        cycle(0, 8'h00, 1, 8'h0D, 0, 0, 0);      // idx 1, period 5
        chk("R6 count unchanged", count, 0);
        chk("R6 no start", env_start, 0);
        chk("R10 period while disabled", period_hi, 5);
        cycle(0, 8'h00, 1, 8'h00, 1, 1, 0);      // enable and write together
        chk("R7 same-cycle enable not seen", count, 0);
        cycle(0, 8'h00, 1, 8'h08, 0, 0, 0);
        chk("R5 load after enable", count, 254);
    endtask

    task automatic t_collide();
        cycle(0, 8'h00, 1, 8'd4 << 3, 0, 0, 1);  // write and strobe together
        chk("R11 write beats strobe", count, 40);
        chk("R8 start on collision", env_start, 1);
        cycle(0, 8'h00, 1, 8'd8 << 3, 1, 0, 0);  // disable and write together
        chk("R11 disable beats write", count, 0);
        chk("R11 no start when disabled", env_start, 0);
    endtask

    initial begin
        rst_n = 0; ctrl_we = 0; len_we = 0; en_we = 0; en_bit = 0; half_tick = 0;
        ctrl_data = 0; len_data = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_load_all();
        t_decrement();
        t_hold();
        t_disabled();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule